// File: doc/BRIEF.md
# Flash Buffered Write Engine

This block carries out the buffered-program operation of a parallel flash bank. The command sequencer pulses `start` once it has taken the buffered-write command. The next write on the command/data port gives a word count. Its address picks an aligned write block. The engine then copies that whole block from the storage array into a private staging buffer. The data writes that follow go into the staging buffer, never straight to the array.

After the last data write the engine waits for one confirm write. If the confirm byte is 0xD0 and the sequencer's program-error status bit is clear, the engine copies the staging buffer back into the array. It writes one word per cycle and holds `busy` until the copy ends. Any other confirm byte, or a program error seen earlier, throws the buffer away and asks the sequencer to go back to plain array reads. The status register belongs to the sequencer. The engine only sends one-cycle pulses that set its ready bit and its program-error bit.

The bank is `BANK_BYTES` wide and is built from devices `DEV_BYTES` wide, where 0 means the device width is not given. The write-block size and the width of the count field both follow from these two parameters. Addresses on both ports are word addresses, one word being the width of the bank.

Top module: `flash_bufwrite_engine`

## Requirements
- R1: Reset and idle state. After reset `busy`, `buf_active`, `arr_rd_en` and `arr_wr_en` are all 0. No event pulse fires until the next operation.
- R2: Word count. The first write after `start` gives the count as N-1, and the engine then takes exactly N data writes before it waits for the confirm write. Only the low 8×DEV_BYTES bits of `wr_data` form the count, or the low 8×BANK_BYTES bits when DEV_BYTES is 0; higher bits are ignored.
- R3: Preload. The buffer base is the address of the count write with its low block-index bits cleared. Every word of that block is read from the array into the buffer, so that on commit the words that were not written keep their old values.
- R4: Block size. The write block holds 2^8 bytes when BANK_BYTES is 1 and 2^11 bytes otherwise, multiplied by BANK_BYTES/DEV_BYTES devices (one device when DEV_BYTES is 0). With the defaults this is 2048 words of 16 bits.
- R5: Window check. A data write whose word address lies outside [base, base+block words) pulses `set_prog_err` and is not stored.
- R6: Ready on data writes. Every data write pulses `set_ready` once, whether it was stored or rejected.
- R7: Commit. A confirm write whose low byte is 0xD0, taken while `stat_err` is 0, copies the whole buffer back to the block in the array. At the end the engine pulses `set_ready` and `commit_done`, and the engine returns to idle.
- R8: Discard. Any other confirm byte, or a confirm taken while `stat_err` is 1, leaves the array unchanged. The engine pulses `exit_read` and returns to idle.
- R9: Read-only. While `read_only` is 1, each data write pulses `set_prog_err` and stores nothing.
- R10: Buffer-valid flag. `buf_active` goes to 1 on the count write. It drops to 0 when a commit completes, when a buffer is discarded, or on reset. A reset in the middle of an operation discards the buffer without touching the array.
- R11: Copy length. A commit drives `arr_wr_en` for exactly one cycle per block word, all to addresses inside the block. A discard drives it for no cycle.
- R12: Idle writes. Writes on the command/data port while idle, with no `start`, produce no event pulse and no array access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse from the sequencer: a buffered write begins |
| read_only | input | 1 | The array is write-protected |
| stat_err | input | 1 | The sequencer's program-error status bit |
| wr_valid | input | 1 | A write is present on the command/data port |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 8*BANK_BYTES | Write data: count, data word, or confirm byte |
| arr_addr | output | ADDR_W | Storage array word address |
| arr_rd_en | output | 1 | Array read; data is returned one cycle later |
| arr_rd_data | input | 8*BANK_BYTES | Array read data |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wr_data | output | 8*BANK_BYTES | Array write data |
| set_ready | output | 1 | Pulse: set the ready status bit |
| set_prog_err | output | 1 | Pulse: set the program-error status bit |
| exit_read | output | 1 | Pulse: buffer discarded, return to array-read mode |
| commit_done | output | 1 | Pulse: the copy to the array has finished |
| busy | output | 1 | Preload or commit copy in progress |
| buf_active | output | 1 | A buffer base is held and valid |

## Verification
Suppose the count register, the stored base or the preload index goes wrong. The array then ends up different from the expected image, and only after the commit. The check must therefore compare the whole block, including the words that were never written, and not only the words a test wrote. A fault in the state sequence shows sooner, at the confirm write. There the confirm byte gets taken as data, or a data word gets taken as a confirm. The result is a missing or extra `set_ready`, `exit_read` or `commit_done` pulse within two cycles of that write. A wrong window comparison shows one cycle after the offending data write as a `set_prog_err` pulse that should not be there, or as one that is missing.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_PRELOAD,
        ST_DATA,
        ST_CONFIRM,
        ST_COMMIT
    } fbw_state_e;

    typedef struct packed {
        logic ready;
        logic prog_err;
        logic exit_read;
        logic commit_done;
    } fbw_evt_t;

    localparam logic [7:0] CONFIRM_CODE = 8'hD0;

    // Number of devices that share the bank; an unset device width counts as one.
    function automatic int num_devices(input int bank_bytes, input int dev_bytes);
        return (dev_bytes == 0) ? 1 : bank_bytes / dev_bytes;
    endfunction

    // log2 of the write-block size in bytes.
    function automatic int blk_log2_bytes(input int bank_bytes, input int dev_bytes);
        return ((bank_bytes == 1) ? 8 : 11) + $clog2(num_devices(bank_bytes, dev_bytes));
    endfunction

    // Width of the word-count field.
    function automatic int count_bits(input int bank_bytes, input int dev_bytes);
        return 8 * ((dev_bytes == 0) ? bank_bytes : dev_bytes);
    endfunction

endpackage

// File: rtl/fbw_stage_buf.sv
module fbw_stage_buf #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/fbw_walk_ctr.sv
module fbw_walk_ctr #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (adv) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = &idx;

endmodule

// File: rtl/fbw_window.sv
module fbw_window #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 11
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [ADDR_W-IDX_W-1:0] base_hi,
    output logic                    in_win,
    output logic [IDX_W-1:0]        idx
);
    assign in_win = (addr[ADDR_W-1:IDX_W] == base_hi);
    assign idx    = addr[IDX_W-1:0];
endmodule

// File: rtl/flash_bufwrite_engine.sv
module flash_bufwrite_engine
    import fbw_pkg::*;
#(
    parameter int BANK_BYTES = 2,
    parameter int DEV_BYTES  = 1,
    parameter int ADDR_W     = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    read_only,
    input  logic                    stat_err,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [8*BANK_BYTES-1:0] wr_data,
    output logic [ADDR_W-1:0]       arr_addr,
    output logic                    arr_rd_en,
    input  logic [8*BANK_BYTES-1:0] arr_rd_data,
    output logic                    arr_wr_en,
    output logic [8*BANK_BYTES-1:0] arr_wr_data,
    output logic                    set_ready,
    output logic                    set_prog_err,
    output logic                    exit_read,
    output logic                    commit_done,
    output logic                    busy,
    output logic                    buf_active
);
    localparam int DATA_W = 8 * BANK_BYTES;
    localparam int IDX_W  = blk_log2_bytes(BANK_BYTES, DEV_BYTES) - $clog2(BANK_BYTES);
    localparam int HI_W   = ADDR_W - IDX_W;
    localparam int CNT_W  = count_bits(BANK_BYTES, DEV_BYTES);

    fbw_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [HI_W-1:0]   base_hi;
    logic              buf_act;
    fbw_evt_t          evt;

    // preload pipeline
    logic              rd_done;
    logic              cap_v;
    logic [IDX_W-1:0]  cap_idx;

    // shared block walker
    logic              copying;
    logic              walk_adv;
    logic [IDX_W-1:0]  walk_idx;
    logic              walk_last;

    // window and buffer
    logic              in_win;
    logic [IDX_W-1:0]  wr_idx;
    logic              data_take;
    logic              data_ok;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_widx;
    logic [DATA_W-1:0] buf_wdata;
    logic [DATA_W-1:0] buf_rdata;

    assign copying   = (state == ST_PRELOAD) || (state == ST_COMMIT);
    assign arr_rd_en = (state == ST_PRELOAD) && !rd_done;
    assign arr_wr_en = (state == ST_COMMIT);
    assign walk_adv  = arr_rd_en || arr_wr_en;
    assign arr_addr  = {base_hi, walk_idx};
    assign arr_wr_data = buf_rdata;

    assign data_take = wr_valid && (state == ST_DATA);
    assign data_ok   = data_take && !read_only && buf_act && in_win;

    always_comb begin
        if (cap_v) begin
            buf_we    = 1'b1;
            buf_widx  = cap_idx;
            buf_wdata = arr_rd_data;
        end else begin
            buf_we    = data_ok;
            buf_widx  = wr_idx;
            buf_wdata = wr_data;
        end
    end

    fbw_walk_ctr #(.IDX_W(IDX_W)) u_walk (
        .clk  (clk),
        .rst  (rst),
        .clr  (!copying),
        .adv  (walk_adv),
        .idx  (walk_idx),
        .last (walk_last)
    );

    fbw_window #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_win (
        .addr    (wr_addr),
        .base_hi (base_hi),
        .in_win  (in_win),
        .idx     (wr_idx)
    );

    fbw_stage_buf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .widx  (buf_widx),
        .wdata (buf_wdata),
        .ridx  (walk_idx),
        .rdata (buf_rdata)
    );

    // preload read-issue bookkeeping and capture pipeline
    always_ff @(posedge clk) begin
        if (rst || (state != ST_PRELOAD)) begin
            rd_done <= 1'b0;
            cap_v   <= 1'b0;
            cap_idx <= '0;
        end else begin
            if (arr_rd_en && walk_last) begin
                rd_done <= 1'b1;
            end
            cap_v   <= arr_rd_en;
            cap_idx <= walk_idx;
        end
    end

    // operation sequence
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            base_hi <= '0;
            buf_act <= 1'b0;
            evt     <= '0;
        end else begin
            evt <= '0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (wr_valid) begin
                        cnt     <= wr_data[CNT_W-1:0];
                        base_hi <= wr_addr[ADDR_W-1:IDX_W];
                        buf_act <= 1'b1;
                        state   <= ST_PRELOAD;
                    end
                end
                ST_PRELOAD: begin
                    if (cap_v && (&cap_idx)) begin
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (wr_valid) begin
                        evt.ready    <= 1'b1;
                        evt.prog_err <= !data_ok;
                        if (cnt == '0) begin
                            state <= ST_CONFIRM;
                        end
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_CONFIRM: begin
                    if (wr_valid) begin
                        if ((wr_data[7:0] == CONFIRM_CODE) && !stat_err) begin
                            state <= ST_COMMIT;
                        end else begin
                            state          <= ST_IDLE;
                            buf_act        <= 1'b0;
                            evt.exit_read  <= 1'b1;
                        end
                    end
                end
                ST_COMMIT: begin
                    if (walk_last) begin
                        state           <= ST_IDLE;
                        buf_act         <= 1'b0;
                        evt.ready       <= 1'b1;
                        evt.commit_done <= 1'b1;
                    end
                end
                default: begin
                    state   <= ST_IDLE;
                    buf_act <= 1'b0;
                end
            endcase
        end
    end

    assign set_ready    = evt.ready;
    assign set_prog_err = evt.prog_err;
    assign exit_read    = evt.exit_read;
    assign commit_done  = evt.commit_done;
    assign busy         = copying;
    assign buf_active   = buf_act;

endmodule

// File: rtl/flash_bufwrite_checker.sv
module flash_bufwrite_checker #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              arr_rd_en,
    input logic              arr_wr_en,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              set_ready,
    input logic              set_prog_err,
    input logic              exit_read,
    input logic              commit_done,
    input logic              busy,
    input logic              buf_active
);
    a_r10_busy_needs_buffer: assert property (@(posedge clk) disable iff (rst)
        busy |-> buf_active);

    a_r11_no_read_during_write: assert property (@(posedge clk) disable iff (rst)
        !(arr_rd_en && arr_wr_en));

    a_r11_copy_stays_in_block: assert property (@(posedge clk) disable iff (rst)
        (arr_wr_en && $past(arr_wr_en)) |->
            (arr_addr[ADDR_W-1:IDX_W] == $past(arr_addr[ADDR_W-1:IDX_W])));

    a_r5_err_follows_write: assert property (@(posedge clk) disable iff (rst)
        set_prog_err |-> $past(wr_valid));

    a_r6_ready_has_cause: assert property (@(posedge clk) disable iff (rst)
        set_ready |-> ($past(wr_valid) || $past(arr_wr_en)));

    a_r8_single_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exit_read, commit_done}));

    a_r7_done_after_copy: assert property (@(posedge clk) disable iff (rst)
        commit_done |-> $past(arr_wr_en));

    a_r10_flag_low_after_end: assert property (@(posedge clk) disable iff (rst)
        (commit_done || exit_read) |-> !buf_active);
endmodule

bind flash_bufwrite_engine flash_bufwrite_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .arr_rd_en    (arr_rd_en),
    .arr_wr_en    (arr_wr_en),
    .arr_addr     (arr_addr),
    .set_ready    (set_ready),
    .set_prog_err (set_prog_err),
    .exit_read    (exit_read),
    .commit_done  (commit_done),
    .busy         (busy),
    .buf_active   (buf_active)
);

// File: tb/flash_bufwrite_engine_test.sv
module flash_bufwrite_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BLK_WORDS  = 2048;   // R4: 2^11 bytes * 2 devices / 2 bytes per word
    localparam int NVEC       = 7;

    // {count-write addr[12], first data addr[12], count word[16], confirm[8], read_only[1]}
    localparam logic [48:0] VEC [NVEC] = '{
        {12'h005, 12'h000, 16'h0002, 8'hD0, 1'b0},
        {12'h9A3, 12'hFFE, 16'h0001, 8'hD0, 1'b0},
        {12'h010, 12'h020, 16'hAB03, 8'hD0, 1'b0},
        {12'h030, 12'h040, 16'h0001, 8'hFF, 1'b0},
        {12'h050, 12'h060, 16'h0000, 8'hD0, 1'b1},
        {12'h100, 12'h7FF, 16'h0001, 8'hD0, 1'b0},
        {12'h800, 12'h800, 16'h0000, 8'hD0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        read_only = 1'b0;
    logic        stat_err;
    logic        wr_valid = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [11:0] arr_addr;
    logic        arr_rd_en;
    logic [15:0] arr_rd_data;
    logic        arr_wr_en;
    logic [15:0] arr_wr_data;
    logic        set_ready, set_prog_err, exit_read, commit_done, busy, buf_active;

    logic        clr_stat = 1'b0;
    logic        init_req = 1'b0;
    logic [15:0] mem     [DEPTH];
    logic [15:0] exp_mem [DEPTH];

    int n_ready = 0, n_err = 0, n_exit = 0, n_done = 0, n_awr = 0;
    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_bufwrite_engine uut (
        .clk(clk), .rst(rst), .start(start), .read_only(read_only), .stat_err(stat_err),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .arr_addr(arr_addr), .arr_rd_en(arr_rd_en), .arr_rd_data(arr_rd_data),
        .arr_wr_en(arr_wr_en), .arr_wr_data(arr_wr_data),
        .set_ready(set_ready), .set_prog_err(set_prog_err), .exit_read(exit_read),
        .commit_done(commit_done), .busy(busy), .buf_active(buf_active)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h0107) ^ 16'h3C5A);
    endfunction

    // storage array model with one-cycle read latency
    always @(posedge clk) begin
        if (init_req) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= pat(a);
        end else begin
            if (arr_wr_en) mem[arr_addr] <= arr_wr_data;
            if (arr_rd_en) arr_rd_data <= mem[arr_addr];
        end
    end

    // sequencer status model: program-error bit
    always @(posedge clk) begin
        if (rst || clr_stat) stat_err <= 1'b0;
        else if (set_prog_err) stat_err <= 1'b1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (set_ready)    n_ready <= n_ready + 1;
            if (set_prog_err) n_err   <= n_err + 1;
            if (exit_read)    n_exit  <= n_exit + 1;
            if (commit_done)  n_done  <= n_done + 1;
            if (arr_wr_en)    n_awr   <= n_awr + 1;
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: run did not end, actual cycles %0d expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    function automatic int mismatches();
        int m = 0;
        for (int a = 0; a < DEPTH; a++) if (mem[a] !== exp_mem[a]) m++;
        return m;
    endfunction

    initial begin
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = pat(a);
        init_req = 1'b1;
        repeat (3) @(negedge clk);
        init_req = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(!busy && !buf_active, "R1 busy/buf_active after reset", {busy, buf_active}, 0);
        check(!arr_rd_en && !arr_wr_en, "R1 array idle after reset", {arr_rd_en, arr_wr_en}, 0);
        check(mismatches() == 0, "R1 array untouched", mismatches(), 0);

        // R12: writes while idle without start
        begin
            int r0 = n_ready, e0 = n_err, w0 = n_awr;
            do_write(12'h004, 16'h00D0);
            do_write(12'h005, 16'h0003);
            check(n_ready == r0 && n_err == e0, "R12 no events from idle writes", n_ready - r0 + n_err - e0, 0);
            check(n_awr == w0 && !buf_active, "R12 no array write or buffer", n_awr - w0, 0);
        end

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int vi = 0; vi < NVEC; vi++) begin
            logic [11:0] caddr, daddr;
            logic [15:0] cword;
            logic [7:0]  conf;
            logic        ro, any_bad, commit;
            int          nw, r0, e0, x0, d0, w0, nbad;
            logic [11:0] wa [4];
            logic [15:0] wd [4];
            logic        wok [4];
            {caddr, daddr, cword, conf, ro} = VEC[vi];
            nw = int'(cword[7:0]) + 1;     // R2: count masked to the 8-bit device width
            @(negedge clk); clr_stat = 1'b1; read_only = ro;
            @(negedge clk); clr_stat = 1'b0;
            r0 = n_ready; e0 = n_err; x0 = n_exit; d0 = n_done; w0 = n_awr;
            pulse_start();
            do_write(caddr, cword);
            check(buf_active, "R10 flag set after count write", buf_active, 1);
            nbad = 0;
            for (int i = 0; i < nw; i++) begin
                wa[i]  = daddr + 12'(i);
                wd[i]  = 16'hC000 + 16'(vi * 16 + i);
                wok[i] = !ro && (wa[i][11] == caddr[11]);   // R4/R5: block index is addr[10:0]
                if (!wok[i]) nbad++;
                do_write(wa[i], wd[i]);
            end
            any_bad = (nbad != 0);
            commit  = (conf == 8'hD0) && !any_bad;
            do_write(12'h000, {8'h00, conf});
            if (commit) for (int i = 0; i < nw; i++) exp_mem[wa[i]] = wd[i];
            check(n_ready - r0 == nw + (commit ? 1 : 0), $sformatf("R6 ready pulses v%0d", vi),
                  n_ready - r0, nw + (commit ? 1 : 0));
            check(n_err - e0 == nbad, $sformatf("R5/R9 error pulses v%0d", vi), n_err - e0, nbad);
            check(n_done - d0 == (commit ? 1 : 0), $sformatf("R7 commit_done v%0d", vi),
                  n_done - d0, commit ? 1 : 0);
            check(n_exit - x0 == (commit ? 0 : 1), $sformatf("R8 exit_read v%0d", vi),
                  n_exit - x0, commit ? 0 : 1);
            check(n_awr - w0 == (commit ? BLK_WORDS : 0), $sformatf("R11 array writes v%0d", vi),
                  n_awr - w0, commit ? BLK_WORDS : 0);
            check(mismatches() == 0, $sformatf("R3/R7 array image v%0d", vi), mismatches(), 0);
            check(!buf_active && !busy, $sformatf("R10 flag cleared v%0d", vi), buf_active, 0);
        end
        read_only = 1'b0;

        // R10: reset in the middle of an operation
        begin
            int w0;
            @(negedge clk); clr_stat = 1'b1;
            @(negedge clk); clr_stat = 1'b0;
            w0 = n_awr;
            pulse_start();
            do_write(12'h200, 16'h0003);
            do_write(12'h201, 16'hBEEF);
            @(negedge clk); rst = 1'b1;
            @(negedge clk); rst = 1'b0;
            @(negedge clk);
            check(!buf_active && !busy, "R10 reset drops buffer", buf_active, 0);
            do_write(12'h000, 16'h00D0);
            check(n_awr == w0, "R10 no commit after reset", n_awr - w0, 0);
            check(mismatches() == 0, "R10 array unchanged after reset", mismatches(), 0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule